// File: doc/BRIEF.md
# Event Timer with One Comparator Channel

This block is a memory-mapped event timer. It owns one free-running 64-bit up counter and one comparator channel. Software reaches every register through a 32-bit request/response bus. Each 64-bit register appears as a low word and a high word.

A match between the counter and the comparator raises the channel interrupt. In one-shot mode the channel fires a single time. In periodic mode it reloads itself by adding a stored interval to the comparator. The interrupt can be a one-cycle pulse, or a held level that software acknowledges by writing one to the status register.

The bus request side uses a valid/ready handshake. `req_ready` is tied high, so the block never applies back-pressure, and each request with `req_valid` high is accepted on that clock edge. Read data returns on the next cycle with `rsp_valid` high for one cycle. There is no response-side ready, so the requester must take the response in that cycle. Control outputs such as `irq` are plain signals.

Top module: `evt_timer`

## Requirements
- R1: The capability low word (offset 0x000) reads 0x0000_2001: bits 7:0 are revision 0x01, bits 12:8 hold channels minus one (0), and bit 13 reports a 64-bit counter. The high word (0x004) reads the tick period in femtoseconds (`PERIOD_FS`). Writes to either word change nothing.
- R2: In the global configuration word (0x010), bit 0 is the run enable. The counter rises by exactly 1 on every clock edge while it is set and holds while it is clear. Bit 1 is stored and reads back but has no effect. All other bits read 0.
- R3: Writes to the counter words (low 0x0F0, high 0x0F4) take effect only while the run enable is clear. Counter writes made while it is set are ignored.
- R4: In the channel configuration low word (0x100), the following bits are read/write: bit 1 (level = 1, edge = 0), bit 2 (interrupt enable), bit 3 (periodic = 1, one-shot = 0), bit 8 (32-bit mode) and bits 13:9 (route). Bits 4 and 5 read 1. Bit 6 (value-set arm) always reads 0. The high word (0x104) reads 0.
- R5: In one-shot mode, any comparator write (low 0x108, high 0x10C) arms the channel. While the run enable is set, the channel fires once when the counter is at or past the comparator. It then stays quiet until the comparator is written again.
- R6: A comparator write made in periodic mode while value-set is armed loads both that comparator word and the matching word of the interval. Each later match adds the interval to the comparator.
- R7: Value-set clears itself on the next comparator write, whichever half that write targets. A later unarmed write in periodic mode moves the comparator and leaves the interval unchanged.
- R8: In edge mode with the interrupt enabled, `irq` is high for exactly the one cycle after the edge on which the counter first meets the comparator. Status bit 0 (0x020) is not set.
- R9: In level mode, a match sets status bit 0. `irq` then equals status AND interrupt enable. Writing 1 to status bit 0 clears it, and writing 0 leaves it set.
- R10: With the interrupt enable clear, `irq` stays low. A level-mode match still sets status bit 0.
- R11: In 32-bit mode, the match uses only the low 32 bits of the counter and the comparator. The periodic reload then wraps within those 32 bits.
- R12: `req_ready` is always 1. A read accepted on an edge has `rsp_valid` high with its data in the next cycle only. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset of the 32-bit word |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | 32 | Read data |
| irq | output | 1 | Channel interrupt (pulse or level) |

## Verification
Assertions inside the modules check the following on every cycle:
- the counter steps by one while running and holds while stopped, and ignores writes while running;
- value-set disarms after a comparator write;
- a one-shot channel disarms after it fires;
- the periodic reload adds the stored interval, in both 64-bit and 32-bit modes;
- edge mode never sets the status bit;
- an acknowledge clears the status bit;
- a masked interrupt never drives the line;
- each read produces a one-cycle response.

Only the bench's scenarios can show the exact cycle of the first interrupt, the number of periodic pulses inside a window, and the effect of an unarmed comparator write on the interval. The same applies to register readback and the contrast between 32-bit and 64-bit matching on a preset counter.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFF_CAP_LO  = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_CAP_HI  = 12'h004;
  localparam logic [ADDR_W-1:0] OFF_GCFG    = 12'h010;
  localparam logic [ADDR_W-1:0] OFF_STS     = 12'h020;
  localparam logic [ADDR_W-1:0] OFF_CNT_LO  = 12'h0F0;
  localparam logic [ADDR_W-1:0] OFF_CNT_HI  = 12'h0F4;
  localparam logic [ADDR_W-1:0] OFF_CCFG_LO = 12'h100;
  localparam logic [ADDR_W-1:0] OFF_CCFG_HI = 12'h104;
  localparam logic [ADDR_W-1:0] OFF_CMP_LO  = 12'h108;
  localparam logic [ADDR_W-1:0] OFF_CMP_HI  = 12'h10C;

  localparam logic [7:0] CAP_REV      = 8'h01;
  localparam int         CAP_CH_LSB   = 8;
  localparam int         CAP_SIZE_BIT = 13;

  localparam int CF_LVL   = 1;
  localparam int CF_IEN   = 2;
  localparam int CF_PER   = 3;
  localparam int CF_PCAP  = 4;
  localparam int CF_WCAP  = 5;
  localparam int CF_VSET  = 6;
  localparam int CF_M32   = 8;
  localparam int CF_RT_LSB = 9;
  localparam int RT_W     = 5;

  typedef struct packed {
    logic            lvl;
    logic            ien;
    logic            per;
    logic            m32;
    logic [RT_W-1:0] route;
  } chcfg_t;
endpackage

// File: rtl/evt_counter.sv
module evt_counter #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          wr_lo_i,
  input  logic          wr_hi_i,
  input  logic [DW-1:0] wdata_i,
  output logic [2*DW-1:0] cnt_o
);
  localparam int CW = 2 * DW;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (run_i) begin
      cnt_q <= cnt_q + CW'(1);
    end else begin
      if (wr_lo_i) cnt_q[DW-1:0]  <= wdata_i;
      if (wr_hi_i) cnt_q[CW-1:DW] <= wdata_i;
    end
  end

  assign cnt_o = cnt_q;

  // R2 and R3: running counter steps by one, whatever is written
  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |=> cnt_q == $past(cnt_q) + CW'(1));

  assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !wr_lo_i && !wr_hi_i) |=> cnt_q == $past(cnt_q));

  assert_count_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && wr_lo_i) |=> cnt_q[DW-1:0] == $past(wdata_i));
endmodule

// File: rtl/evt_channel.sv
module evt_channel #(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_i,
  input  logic            lvl_i,
  input  logic            ien_i,
  input  logic            per_i,
  input  logic            m32_i,
  input  logic [2*DW-1:0] cnt_i,
  input  logic            wr_lo_i,
  input  logic            wr_hi_i,
  input  logic            vset_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            ack_i,
  output logic [2*DW-1:0] cmp_o,
  output logic            sts_o,
  output logic            irq_o
);
  localparam int CW = 2 * DW;

  logic [CW-1:0] cmp_q, ival_q, cmp_next;
  logic          armed_q, sts_q, pulse_q;
  logic          any_wr, reached, fire;

  always_comb begin
    any_wr  = wr_lo_i | wr_hi_i;
    reached = m32_i ? (cnt_i[DW-1:0] >= cmp_q[DW-1:0]) : (cnt_i >= cmp_q);
    fire    = armed_q & run_i & ~any_wr & reached;
    if (m32_i) cmp_next = {cmp_q[CW-1:DW], cmp_q[DW-1:0] + ival_q[DW-1:0]};
    else       cmp_next = cmp_q + ival_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q   <= '0;
      ival_q  <= '0;
      armed_q <= 1'b0;
      sts_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      if (any_wr) begin
        if (wr_lo_i) cmp_q[DW-1:0]  <= wdata_i;
        if (wr_hi_i) cmp_q[CW-1:DW] <= wdata_i;
        if (vset_i && per_i) begin
          if (wr_lo_i) ival_q[DW-1:0]  <= wdata_i;
          if (wr_hi_i) ival_q[CW-1:DW] <= wdata_i;
        end
        armed_q <= 1'b1;
      end else if (fire) begin
        if (per_i) cmp_q <= cmp_next;
        else       armed_q <= 1'b0;
      end

      if (fire && lvl_i) sts_q <= 1'b1;
      else if (ack_i)    sts_q <= 1'b0;

      pulse_q <= fire & ~lvl_i & ien_i;
    end
  end

  assign cmp_o = cmp_q;
  assign sts_o = sts_q;
  assign irq_o = lvl_i ? (sts_q & ien_i) : pulse_q;

  assert_oneshot_disarm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !per_i) |=> !armed_q);

  assert_periodic_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && per_i && !m32_i) |=> cmp_q == $past(cmp_q) + $past(ival_q));

  assert_reload_wrap32_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && per_i && m32_i) |=>
      cmp_q[DW-1:0] == $past(cmp_q[DW-1:0]) + $past(ival_q[DW-1:0]));

  assert_edge_no_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !lvl_i |=> !$rose(sts_q));

  assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !(fire && lvl_i)) |=> !sts_q);

  assert_masked_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ien_i && $past(!ien_i)) |-> !irq_o);
endmodule

// File: rtl/evt_regbus.sv
module evt_regbus import evt_pkg::*; #(
  parameter int          DW        = 32,
  parameter int unsigned PERIOD_FS = 32'd10_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DW-1:0]     req_wdata_i,
  input  logic [2*DW-1:0]   cnt_i,
  input  logic [2*DW-1:0]   cmp_i,
  input  logic              sts_i,
  output logic              run_o,
  output chcfg_t            cfg_o,
  output logic              vset_o,
  output logic              cnt_wr_lo_o,
  output logic              cnt_wr_hi_o,
  output logic              cmp_wr_lo_o,
  output logic              cmp_wr_hi_o,
  output logic              ack_o,
  output logic              rsp_valid_o,
  output logic [DW-1:0]     rsp_rdata_o
);
  localparam int CW = 2 * DW;

  logic          wr_en, rd_en;
  logic          run_q, legacy_q, vset_q;
  chcfg_t        cfg_q;
  logic [DW-1:0] rd_word;
  logic          rsp_valid_q;
  logic [DW-1:0] rsp_rdata_q;

  always_comb begin
    wr_en       = req_valid_i & req_write_i;
    rd_en       = req_valid_i & ~req_write_i;
    cnt_wr_lo_o = wr_en && (req_addr_i == OFF_CNT_LO);
    cnt_wr_hi_o = wr_en && (req_addr_i == OFF_CNT_HI);
    cmp_wr_lo_o = wr_en && (req_addr_i == OFF_CMP_LO);
    cmp_wr_hi_o = wr_en && (req_addr_i == OFF_CMP_HI);
    ack_o       = wr_en && (req_addr_i == OFF_STS) && req_wdata_i[0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      legacy_q <= 1'b0;
      cfg_q    <= '0;
      vset_q   <= 1'b0;
    end else begin
      if (wr_en && req_addr_i == OFF_GCFG) begin
        run_q    <= req_wdata_i[0];
        legacy_q <= req_wdata_i[1];
      end
      if (wr_en && req_addr_i == OFF_CCFG_LO) begin
        cfg_q.lvl   <= req_wdata_i[CF_LVL];
        cfg_q.ien   <= req_wdata_i[CF_IEN];
        cfg_q.per   <= req_wdata_i[CF_PER];
        cfg_q.m32   <= req_wdata_i[CF_M32];
        cfg_q.route <= req_wdata_i[CF_RT_LSB +: RT_W];
        if (req_wdata_i[CF_VSET]) vset_q <= 1'b1;
      end else if (cmp_wr_lo_o || cmp_wr_hi_o) begin
        vset_q <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_word = '0;
    case (req_addr_i)
      OFF_CAP_LO: begin
        rd_word[7:0]                 = CAP_REV;
        rd_word[CAP_CH_LSB +: 5]     = 5'd0;
        rd_word[CAP_SIZE_BIT]        = 1'b1;
      end
      OFF_CAP_HI:  rd_word = DW'(PERIOD_FS);
      OFF_GCFG:    rd_word[1:0] = {legacy_q, run_q};
      OFF_STS:     rd_word[0] = sts_i;
      OFF_CNT_LO:  rd_word = cnt_i[DW-1:0];
      OFF_CNT_HI:  rd_word = cnt_i[CW-1:DW];
      OFF_CCFG_LO: begin
        rd_word[CF_LVL]              = cfg_q.lvl;
        rd_word[CF_IEN]              = cfg_q.ien;
        rd_word[CF_PER]              = cfg_q.per;
        rd_word[CF_PCAP]             = 1'b1;
        rd_word[CF_WCAP]             = 1'b1;
        rd_word[CF_M32]              = cfg_q.m32;
        rd_word[CF_RT_LSB +: RT_W]   = cfg_q.route;
      end
      OFF_CCFG_HI: rd_word = '0;
      OFF_CMP_LO:  rd_word = cmp_i[DW-1:0];
      OFF_CMP_HI:  rd_word = cmp_i[CW-1:DW];
      default:     rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= rd_en;
      if (rd_en) rsp_rdata_q <= rd_word;
    end
  end

  assign run_o       = run_q;
  assign cfg_o       = cfg_q;
  assign vset_o      = vset_q;
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_rdata_q;

  assert_vset_disarm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_wr_lo_o || cmp_wr_hi_o) |=> !vset_q);

  assert_read_resp_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && !req_write_i) |=> rsp_valid_q);

  assert_no_spurious_resp_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid_i && !req_write_i) |=> !rsp_valid_q);
endmodule

// File: rtl/evt_timer.sv
module evt_timer import evt_pkg::*; #(
  parameter int          DW        = 32,
  parameter int unsigned PERIOD_FS = 32'd10_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  output logic              irq
);
  localparam int CW = 2 * DW;

  logic          run, vset, cnt_wr_lo, cnt_wr_hi, cmp_wr_lo, cmp_wr_hi, ack, sts;
  chcfg_t        cfg;
  logic [CW-1:0] cnt, cmp;

  assign req_ready = 1'b1;

  evt_regbus #(.DW(DW), .PERIOD_FS(PERIOD_FS)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid),
    .req_write_i (req_write),
    .req_addr_i  (req_addr),
    .req_wdata_i (req_wdata),
    .cnt_i       (cnt),
    .cmp_i       (cmp),
    .sts_i       (sts),
    .run_o       (run),
    .cfg_o       (cfg),
    .vset_o      (vset),
    .cnt_wr_lo_o (cnt_wr_lo),
    .cnt_wr_hi_o (cnt_wr_hi),
    .cmp_wr_lo_o (cmp_wr_lo),
    .cmp_wr_hi_o (cmp_wr_hi),
    .ack_o       (ack),
    .rsp_valid_o (rsp_valid),
    .rsp_rdata_o (rsp_rdata)
  );

  evt_counter #(.DW(DW)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (run),
    .wr_lo_i (cnt_wr_lo),
    .wr_hi_i (cnt_wr_hi),
    .wdata_i (req_wdata),
    .cnt_o   (cnt)
  );

  evt_channel #(.DW(DW)) u_ch0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (run),
    .lvl_i   (cfg.lvl),
    .ien_i   (cfg.ien),
    .per_i   (cfg.per),
    .m32_i   (cfg.m32),
    .cnt_i   (cnt),
    .wr_lo_i (cmp_wr_lo),
    .wr_hi_i (cmp_wr_hi),
    .vset_i  (vset),
    .wdata_i (req_wdata),
    .ack_i   (ack),
    .cmp_o   (cmp),
    .sts_o   (sts),
    .irq_o   (irq)
  );
endmodule

// File: tb/sim_evt_timer.sv
`timescale 1ns/1ps
module sim_evt_timer;
  localparam real CLK_NS = 4.0;
  localparam logic [11:0] A_CAPL = 12'h000, A_CAPH = 12'h004, A_GCFG = 12'h010,
                          A_STS  = 12'h020, A_CNTL = 12'h0F0, A_CNTH = 12'h0F4,
                          A_CCFG = 12'h108 - 12'h008, A_CMPL = 12'h108, A_CMPH = 12'h10C;
  localparam int NV = 6;
  // periodic, level, comparator, window
  localparam int VECS [0:NV-1][0:3] = '{
    '{0, 0, 20, 80}, '{1, 0, 15, 100}, '{0, 1, 9, 40},
    '{1, 0, 7, 60},  '{0, 0, 3, 30},   '{1, 1, 12, 50}};

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, irq;
  logic [31:0] rsp_rdata;
  int cyc = 0, last_acc = 0, nchk = 0, nfail = 0;
  bit done = 0;

  evt_timer u0 (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq(irq));

  always #(CLK_NS/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    last_acc = cyc; req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; d = rsp_rdata; v = rsp_valid;
  endtask

  task automatic watch(input int win, input int e, output int first, output int rises,
                       output int highs);
    logic prev = 0;
    first = -1; rises = 0; highs = 0;
    for (int k = 1; k <= win; k++) begin
      @(negedge clk);
      if (irq) begin
        highs++;
        if (!prev) begin
          rises++;
          if (first < 0) first = cyc - e;
        end
      end
      prev = irq;
    end
  endtask

  task automatic run_vec(input int per, input int lvl, input int cmpv, input int win);
    logic [31:0] cfg, d;
    logic v;
    int first, rises, highs, exp_r, exp_h;
    wr(A_GCFG, 0); wr(A_STS, 1); wr(A_CNTL, 0); wr(A_CNTH, 0);
    cfg = 32'(lvl << 1) | 32'h4 | 32'(per << 3) | 32'h40;
    wr(A_CCFG, cfg); wr(A_CMPL, 32'(cmpv));
    wr(A_CCFG, cfg); wr(A_CMPH, 0);
    wr(A_GCFG, 1);
    watch(win, last_acc, first, rises, highs);
    wr(A_GCFG, 0);
    exp_r = (lvl != 0 || per == 0) ? 1 : (win - cmpv - 1) / cmpv + 1;
    exp_h = (lvl != 0) ? win - cmpv : exp_r;
    if (per != 0) begin
      chk("R6 first fire", 64'(first), 64'(cmpv + 1));
      chk("R6 fire count", 64'(rises), 64'(exp_r));
    end else begin
      chk("R5 first fire", 64'(first), 64'(cmpv + 1));
      chk("R5 single fire", 64'(rises), 64'(exp_r));
    end
    if (lvl != 0) chk("R9 level high cycles", 64'(highs), 64'(exp_h));
    else begin
      chk("R8 pulse width", 64'(highs), 64'(exp_h));
      rd(A_STS, d, v);
      chk("R8 status stays clear", 64'(d), 64'h0);
    end
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL R12 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic v;
    int first, rises, highs, e_on, e_off;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    chk("R8 irq low after reset", 64'(irq), 64'h0);
    chk("R12 ready high", 64'(req_ready), 64'h1);
    rd(A_CAPL, d, v); chk("R1 cap low", 64'(d), 64'h2001);
    chk("R12 rsp valid", 64'(v), 64'h1);
    rd(A_CAPH, d, v); chk("R1 cap high period", 64'(d), 64'd10000000);
    rd(A_GCFG, d, v); chk("R2 gcfg reset", 64'(d), 64'h0);
    rd(A_CCFG, d, v); chk("R4 ccfg reset", 64'(d), 64'h30);
    // R1 read-only
    wr(A_CAPL, 0); wr(A_CAPH, 0);
    rd(A_CAPL, d, v); chk("R1 cap low after write", 64'(d), 64'h2001);
    rd(A_CAPH, d, v); chk("R1 cap high after write", 64'(d), 64'd10000000);
    // R3 load while stopped, R2 hold and legacy bit
    wr(A_CNTL, 5); wr(A_CNTH, 7);
    rd(A_CNTL, d, v); chk("R3 counter low load", 64'(d), 64'h5);
    rd(A_CNTH, d, v); chk("R3 counter high load", 64'(d), 64'h7);
    wr(A_GCFG, 2);
    rd(A_GCFG, d, v); chk("R2 legacy bit stored", 64'(d), 64'h2);
    rd(A_CNTL, d, v); chk("R2 no count while disabled", 64'(d), 64'h5);
    // R3 writes ignored while running, R2 step rate
    wr(A_GCFG, 0); wr(A_CNTL, 0); wr(A_CNTH, 0);
    wr(A_GCFG, 1); e_on = last_acc;
    wr(A_CNTL, 32'hFFFF0000);
    wr(A_GCFG, 0); e_off = last_acc;
    rd(A_CNTL, d, v); chk("R3 write ignored, R2 one per clock", 64'(d), 64'(e_off - e_on));
    rd(A_CNTH, d, v); chk("R3 high unchanged", 64'(d), 64'h0);
    // R4 configuration fields
    wr(A_CCFG, 32'hFFFFFFFF);
    rd(A_CCFG, d, v); chk("R4 ccfg writable mask, bit6 zero", 64'(d), 64'h3F3E);
    rd(A_CCFG + 12'h004, d, v); chk("R4 ccfg high zero", 64'(d), 64'h0);
    wr(A_CMPL, 0); wr(A_CCFG, 0);
    // table of scenarios
    for (int i = 0; i < NV; i++) run_vec(VECS[i][0], VECS[i][1], VECS[i][2], VECS[i][3]);
    // R7 unarmed write keeps the interval
    wr(A_CNTL, 0);
    wr(A_CCFG, 32'h4C); wr(A_CMPL, 10);
    rd(A_CCFG, d, v); chk("R7 value-set reads 0 after write", 64'(d[6]), 64'h0);
    wr(A_CMPL, 50);
    wr(A_GCFG, 1);
    watch(75, last_acc, first, rises, highs);
    wr(A_GCFG, 0);
    chk("R7 first fire at new comparator", 64'(first), 64'd51);
    chk("R7 interval kept at 10", 64'(rises), 64'd3);
    // R9 acknowledge
    wr(A_STS, 1); wr(A_CNTL, 0);
    wr(A_CCFG, 32'h46); wr(A_CMPL, 5); wr(A_CCFG, 32'h46); wr(A_CMPH, 0);
    wr(A_GCFG, 1);
    repeat (10) @(negedge clk);
    rd(A_STS, d, v); chk("R9 status set", 64'(d), 64'h1);
    chk("R9 irq held", 64'(irq), 64'h1);
    wr(A_STS, 0); chk("R9 write 0 keeps irq", 64'(irq), 64'h1);
    wr(A_STS, 1); chk("R9 write 1 clears irq", 64'(irq), 64'h0);
    repeat (10) @(negedge clk);
    chk("R5 one-shot no refire", 64'(irq), 64'h0);
    rd(A_STS, d, v); chk("R5 status stays clear", 64'(d), 64'h0);
    wr(A_GCFG, 0);
    // R10 masked
    wr(A_CNTL, 0);
    wr(A_CCFG, 32'h42); wr(A_CMPL, 4); wr(A_CCFG, 32'h42); wr(A_CMPH, 0);
    wr(A_GCFG, 1);
    watch(10, last_acc, first, rises, highs);
    wr(A_GCFG, 0);
    chk("R10 masked irq quiet", 64'(highs), 64'h0);
    rd(A_STS, d, v); chk("R10 status still set", 64'(d), 64'h1);
    wr(A_STS, 1);
    // R11 32-bit match versus 64-bit match
    wr(A_CNTL, 0); wr(A_CNTH, 1);
    wr(A_CCFG, 32'h144); wr(A_CMPL, 10); wr(A_CCFG, 32'h144); wr(A_CMPH, 0);
    wr(A_GCFG, 1);
    watch(20, last_acc, first, rises, highs);
    wr(A_GCFG, 0);
    chk("R11 low-word match", 64'(first), 64'd11);
    wr(A_CNTL, 0); wr(A_CNTH, 1);
    wr(A_CCFG, 32'h44); wr(A_CMPL, 10); wr(A_CCFG, 32'h44); wr(A_CMPH, 0);
    wr(A_GCFG, 1);
    watch(20, last_acc, first, rises, highs);
    wr(A_GCFG, 0);
    chk("R11 full-width already passed", 64'(first), 64'd1);
    // R12 unmapped
    rd(12'h040, d, v); chk("R12 unmapped reads 0", 64'(d), 64'h0);
    @(negedge clk); chk("R12 response lasts one cycle", 64'(rsp_valid), 64'h0);
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule